// File: doc/BRIEF.md
# Keyed Flash Command Port

This block is a byte-wide command front end for an on-chip non-volatile array. A host talks to it through one 8-bit data port and reads a 2-bit status word. Every command opens with an unlock sequence: a fixed first key byte, then a second key that depends on the opcode, then the opcode itself. The block then collects the opcode's parameter bytes, runs the operation against the array it holds, and hands any result bytes back through the same data port, one per read strobe.

The array is modelled behaviourally: `NUM_SECTORS` sectors of `ROWS_PER_SECTOR` rows of `ROW_BYTES` bytes. There is also a row latch that is filled before a row program, and one protection row. Erased storage reads as 0x00. When the `ecc_bypass` pin is high, a row load carries `ROW_BYTES/8` extra check/config bytes after the data. The port consumes those bytes and drops them. The array ID parameter byte is accepted and consumed but does not select anything, because a single array is modelled.

The sequencer has seven states:

- **IDLE** waits for the first key.
- **KEY2** stores the second key.
- **OPCODE** checks the key pair and the opcode. It moves to PARAM, or to EXEC when the opcode takes no parameters, or back to IDLE on a mismatch.
- **PARAM** gathers parameters. After the last one it moves to ROWDATA for a row load, otherwise to EXEC.
- **ROWDATA** streams the row bytes and moves to EXEC.
- **EXEC** waits `BUSY_CYCLES` cycles, applies the operation on its last cycle, then moves to RESULT or to IDLE.
- **RESULT** presents result bytes and returns to IDLE after the last read.

Top module: `flash_cmd_port`

## Requirements
- R1: After reset, status is 2'b10 (idle=1, ready=0), rd_data is 0x00 and the whole array, latch and protection row read as 0x00.
- R2: A command is the byte 0xB6, then (0xD3 + opcode) mod 256, then the opcode, each written with wr_en. status[1] (idle) goes to 0 in the cycle after the 0xB6 write and stays 0 until the command finishes.
- R3: In IDLE, any written byte other than 0xB6 is ignored. A second key that does not match the opcode, or an unsupported opcode (0x01, 0x04, 0x05, 0x06, 0x0C, 0x10 or any other value outside the set below), returns the block to IDLE and changes no stored data.
- R4: status[0] is data-ready and status[1] is idle. They are never 1 together.
- R5: Read byte (0x03) takes an array ID and a byte offset. After EXEC, ready is 1 and rd_data holds the array byte at that offset (row = offset / ROW_BYTES). One rd_en clears ready and sets idle.
- R6: Load byte (0x00) takes an array ID, a latch index and a data byte, and writes the latch. Program row (0x07) takes an array ID, a row number (high byte, then low byte) and two temperature bytes. It copies the latch into row (number mod row count), with no data phase.
- R7: Load row (0x02) takes an array ID and then ROW_BYTES bytes into latch positions 0 upward. With ecc_bypass=1, ROW_BYTES/8 further bytes are consumed and discarded, so a 0xB6 among them starts no command.
- R8: Erase sector (0x08) takes an array ID and a sector index. It sets the rows of sector (index mod NUM_SECTORS) to 0x00, leaves all other rows unchanged and has no data phase.
- R9: Erase all (0x09) takes no parameters. It clears every array row, the row latch and the protection row.
- R10: Program protect row (0x0B) takes an array ID and copies the latch into the protection row. Read hidden row (0x0A) takes an array ID and a row ID, then returns ROW_BYTES protection-row bytes, index 0 first.
- R11: Get temperature (0x0E) takes one sample-count byte and returns two bytes: TEMP_SIGN, then TEMP_MAG.
- R12: Writes during EXEC or RESULT are ignored. rd_data is 0x00 whenever ready is 0, and rd_en outside RESULT has no effect.
- R13: EXEC lasts exactly BUSY_CYCLES cycles, with status 2'b00 throughout.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| ecc_bypass | input | 1 | 1: row loads carry extra check/config bytes |
| wr_en | input | 1 | Write strobe for wr_data |
| wr_data | input | 8 | Key, opcode, parameter or row byte |
| rd_en | input | 1 | Consumes the current result byte |
| rd_data | output | 8 | Current result byte, 0x00 when not ready |
| status | output | 2 | Bit 0 data-ready, bit 1 idle |

## Verification
The assertions take for granted that rd_en is raised only to consume a presented byte, and that ecc_bypass does not change while a row load is in progress. The stimulus changes ecc_bypass only once status reports idle, and it changes inputs only at the falling clock edge. Before each new command it waits for idle, except in the cases that deliberately write during EXEC and RESULT to show that those writes are dropped. A behavioural model with byte queues predicts status and rd_data for every cycle.

// File: rtl/flc_pkg.sv
package flc_pkg;

    localparam logic [7:0] KEY_FIRST  = 8'hB6;
    localparam logic [7:0] KEY_OFFSET = 8'hD3;

    typedef enum logic [7:0] {
        OP_LOAD_BYTE   = 8'h00,
        OP_LOAD_ROW    = 8'h02,
        OP_READ_BYTE   = 8'h03,
        OP_PROG_ROW    = 8'h07,
        OP_ERASE_SECT  = 8'h08,
        OP_ERASE_ALL   = 8'h09,
        OP_READ_HIDDEN = 8'h0A,
        OP_PROG_PROT   = 8'h0B,
        OP_GET_TEMP    = 8'h0E
    } op_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_KEY2,
        S_OPCODE,
        S_PARAM,
        S_ROWDATA,
        S_EXEC,
        S_RESULT
    } state_e;

    // Opcode is one the port executes
    function automatic logic op_known(input logic [7:0] code);
        case (code)
            OP_LOAD_BYTE, OP_LOAD_ROW, OP_READ_BYTE, OP_PROG_ROW,
            OP_ERASE_SECT, OP_ERASE_ALL, OP_READ_HIDDEN, OP_PROG_PROT,
            OP_GET_TEMP: return 1'b1;
            default:     return 1'b0;
        endcase
    endfunction

    // Parameter bytes following the opcode (row data excluded)
    function automatic logic [2:0] op_nparam(input logic [7:0] code);
        case (code)
            OP_LOAD_BYTE:   return 3'd3;
            OP_LOAD_ROW:    return 3'd1;
            OP_READ_BYTE:   return 3'd2;
            OP_PROG_ROW:    return 3'd5;
            OP_ERASE_SECT:  return 3'd2;
            OP_READ_HIDDEN: return 3'd2;
            OP_PROG_PROT:   return 3'd1;
            OP_GET_TEMP:    return 3'd1;
            default:        return 3'd0;
        endcase
    endfunction

endpackage

// File: rtl/flc_sequencer.sv
module flc_sequencer
    import flc_pkg::*;
#(
    parameter  int ROW_BYTES   = 16,
    parameter  int ECC_BYTES   = 2,
    parameter  int BUSY_CYCLES = 4,
    localparam int IDX_W       = $clog2(ROW_BYTES),
    localparam int CNT_W       = $clog2(ROW_BYTES + ECC_BYTES + 1),
    localparam int BSY_W       = $clog2(BUSY_CYCLES + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ecc_bypass,
    input  logic             wr_en,
    input  logic [7:0]       wr_data,
    input  logic             rd_en,
    output logic             go,
    output logic [7:0]       op,
    output logic [7:0]       arg_a,
    output logic [7:0]       arg_b,
    output logic             lat_we,
    output logic [IDX_W-1:0] lat_idx,
    output logic [7:0]       lat_data,
    output logic             ready,
    output logic             idle,
    output logic [CNT_W-1:0] res_idx
);

    state_e             state_q, state_d;
    logic [7:0]         key2_q;
    logic [7:0]         op_q;
    logic [7:0]         arg_a_q, arg_b_q;
    logic [2:0]         pcnt_q;
    logic [CNT_W-1:0]   cnt_q;
    logic [BSY_W-1:0]   busy_q;

    logic               key_ok;
    logic [2:0]         nprm;
    logic [CNT_W-1:0]   row_len;
    logic [CNT_W-1:0]   nres;

    assign key_ok  = op_known(wr_data) && (key2_q == 8'(KEY_OFFSET + wr_data));
    assign nprm    = op_nparam(op_q);
    assign row_len = ecc_bypass ? CNT_W'(ROW_BYTES + ECC_BYTES) : CNT_W'(ROW_BYTES);

    always_comb begin
        case (op_q)
            OP_READ_BYTE:   nres = CNT_W'(1);
            OP_READ_HIDDEN: nres = CNT_W'(ROW_BYTES);
            OP_GET_TEMP:    nres = CNT_W'(2);
            default:        nres = '0;
        endcase
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:    if (wr_en && wr_data == KEY_FIRST) state_d = S_KEY2;
            S_KEY2:    if (wr_en) state_d = S_OPCODE;
            S_OPCODE:  if (wr_en) begin
                           if (!key_ok)                      state_d = S_IDLE;
                           else if (op_nparam(wr_data) == 0) state_d = S_EXEC;
                           else                              state_d = S_PARAM;
                       end
            S_PARAM:   if (wr_en && pcnt_q == nprm - 3'd1)
                           state_d = (op_q == OP_LOAD_ROW) ? S_ROWDATA : S_EXEC;
            S_ROWDATA: if (wr_en && cnt_q == row_len - CNT_W'(1)) state_d = S_EXEC;
            S_EXEC:    if (busy_q == '0) state_d = (nres != '0) ? S_RESULT : S_IDLE;
            S_RESULT:  if (rd_en && cnt_q == nres - CNT_W'(1)) state_d = S_IDLE;
            default:   state_d = S_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // Key, opcode, parameter and counter registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            key2_q  <= '0;
            op_q    <= '0;
            arg_a_q <= '0;
            arg_b_q <= '0;
            pcnt_q  <= '0;
            cnt_q   <= '0;
            busy_q  <= '0;
        end else begin
            unique case (state_q)
                S_KEY2:    if (wr_en) key2_q <= wr_data;
                S_OPCODE:  if (wr_en) begin
                               op_q   <= wr_data;
                               pcnt_q <= '0;
                               busy_q <= BSY_W'(BUSY_CYCLES - 1);
                           end
                S_PARAM:   if (wr_en) begin
                               if (pcnt_q == 3'd1) arg_a_q <= wr_data;
                               if (pcnt_q == 3'd2) arg_b_q <= wr_data;
                               pcnt_q <= pcnt_q + 3'd1;
                               cnt_q  <= '0;
                           end
                S_ROWDATA: if (wr_en) cnt_q <= cnt_q + CNT_W'(1);
                S_EXEC:    begin
                               busy_q <= busy_q - BSY_W'(1);
                               cnt_q  <= '0;
                           end
                S_RESULT:  if (rd_en) cnt_q <= cnt_q + CNT_W'(1);
                default:   ;
            endcase
        end
    end

    // Outputs
    always_comb begin
        idle     = (state_q == S_IDLE);
        ready    = (state_q == S_RESULT);
        go       = (state_q == S_EXEC) && (busy_q == '0);
        lat_we   = (state_q == S_ROWDATA) && wr_en && (cnt_q < CNT_W'(ROW_BYTES));
        lat_idx  = cnt_q[IDX_W-1:0];
        lat_data = wr_data;
        res_idx  = cnt_q;
        op       = op_q;
        arg_a    = arg_a_q;
        arg_b    = arg_b_q;
    end

endmodule

// File: rtl/flc_store.sv
module flc_store
    import flc_pkg::*;
#(
    parameter  int ROW_BYTES       = 16,
    parameter  int ROWS_PER_SECTOR = 4,
    parameter  int NUM_SECTORS     = 4,
    localparam int NUM_ROWS        = ROWS_PER_SECTOR * NUM_SECTORS,
    localparam int TOTAL           = NUM_ROWS * ROW_BYTES,
    localparam int IDX_W           = $clog2(ROW_BYTES),
    localparam int ROW_W           = $clog2(NUM_ROWS),
    localparam int SEC_W           = $clog2(NUM_SECTORS),
    localparam int ADDR_W          = $clog2(TOTAL)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go,
    input  logic [7:0]        op,
    input  logic [7:0]        arg_a,
    input  logic [7:0]        arg_b,
    input  logic              lat_we,
    input  logic [IDX_W-1:0]  lat_idx,
    input  logic [7:0]        lat_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [7:0]        rd_byte,
    input  logic [IDX_W-1:0]  prot_idx,
    output logic [7:0]        prot_byte
);

    logic [7:0] mem   [NUM_ROWS][ROW_BYTES];
    logic [7:0] latch [ROW_BYTES];
    logic [7:0] prot  [ROW_BYTES];

    logic [15:0]      row_num;
    logic [ROW_W-1:0] prog_row;
    logic [SEC_W-1:0] sect;
    logic [IDX_W-1:0] ld_idx;

    assign row_num  = {arg_a, arg_b};
    assign prog_row = row_num[ROW_W-1:0];
    assign sect     = arg_a[SEC_W-1:0];
    assign ld_idx   = arg_a[IDX_W-1:0];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int r = 0; r < NUM_ROWS; r++)
                for (int b = 0; b < ROW_BYTES; b++) mem[r][b] <= '0;
            for (int b = 0; b < ROW_BYTES; b++) begin
                latch[b] <= '0;
                prot[b]  <= '0;
            end
        end else begin
            if (lat_we) latch[lat_idx] <= lat_data;
            if (go) begin
                case (op)
                    OP_LOAD_BYTE:  latch[ld_idx] <= arg_b;
                    OP_PROG_ROW:   for (int b = 0; b < ROW_BYTES; b++)
                                       mem[prog_row][b] <= latch[b];
                    OP_ERASE_SECT: for (int r = 0; r < ROWS_PER_SECTOR; r++)
                                       for (int b = 0; b < ROW_BYTES; b++)
                                           mem[ROW_W'(int'(sect) * ROWS_PER_SECTOR + r)][b] <= '0;
                    OP_ERASE_ALL:  begin
                                       for (int r = 0; r < NUM_ROWS; r++)
                                           for (int b = 0; b < ROW_BYTES; b++) mem[r][b] <= '0;
                                       for (int b = 0; b < ROW_BYTES; b++) begin
                                           latch[b] <= '0;
                                           prot[b]  <= '0;
                                       end
                                   end
                    OP_PROG_PROT:  for (int b = 0; b < ROW_BYTES; b++) prot[b] <= latch[b];
                    default:       ;
                endcase
            end
        end
    end

    assign rd_byte   = mem[rd_addr[ADDR_W-1:IDX_W]][rd_addr[IDX_W-1:0]];
    assign prot_byte = prot[prot_idx];

endmodule

// File: rtl/flash_cmd_port.sv
module flash_cmd_port
    import flc_pkg::*;
#(
    parameter int         ROW_BYTES       = 16,
    parameter int         ROWS_PER_SECTOR = 4,
    parameter int         NUM_SECTORS     = 4,
    parameter int         BUSY_CYCLES     = 4,
    parameter logic [7:0] TEMP_SIGN       = 8'h00,
    parameter logic [7:0] TEMP_MAG        = 8'h19
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ecc_bypass,
    input  logic       wr_en,
    input  logic [7:0] wr_data,
    input  logic       rd_en,
    output logic [7:0] rd_data,
    output logic [1:0] status
);

    localparam int ECC_BYTES = ROW_BYTES / 8;
    localparam int IDX_W     = $clog2(ROW_BYTES);
    localparam int CNT_W     = $clog2(ROW_BYTES + ECC_BYTES + 1);
    localparam int ADDR_W    = $clog2(ROWS_PER_SECTOR * NUM_SECTORS * ROW_BYTES);

    logic             go, lat_we, ready, idle;
    logic [7:0]       op, arg_a, arg_b, lat_data, flash_byte, prot_byte;
    logic [IDX_W-1:0] lat_idx;
    logic [CNT_W-1:0] res_idx;

    flc_sequencer #(
        .ROW_BYTES   (ROW_BYTES),
        .ECC_BYTES   (ECC_BYTES),
        .BUSY_CYCLES (BUSY_CYCLES)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .ecc_bypass (ecc_bypass),
        .wr_en      (wr_en),
        .wr_data    (wr_data),
        .rd_en      (rd_en),
        .go         (go),
        .op         (op),
        .arg_a      (arg_a),
        .arg_b      (arg_b),
        .lat_we     (lat_we),
        .lat_idx    (lat_idx),
        .lat_data   (lat_data),
        .ready      (ready),
        .idle       (idle),
        .res_idx    (res_idx)
    );

    flc_store #(
        .ROW_BYTES       (ROW_BYTES),
        .ROWS_PER_SECTOR (ROWS_PER_SECTOR),
        .NUM_SECTORS     (NUM_SECTORS)
    ) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .go        (go),
        .op        (op),
        .arg_a     (arg_a),
        .arg_b     (arg_b),
        .lat_we    (lat_we),
        .lat_idx   (lat_idx),
        .lat_data  (lat_data),
        .rd_addr   (ADDR_W'(arg_a)),
        .rd_byte   (flash_byte),
        .prot_idx  (res_idx[IDX_W-1:0]),
        .prot_byte (prot_byte)
    );

    // Result byte selection
    always_comb begin
        rd_data = '0;
        if (ready) begin
            case (op)
                OP_READ_BYTE:   rd_data = flash_byte;
                OP_READ_HIDDEN: rd_data = prot_byte;
                OP_GET_TEMP:    rd_data = (res_idx == '0) ? TEMP_SIGN : TEMP_MAG;
                default:        rd_data = '0;
            endcase
        end
    end

    assign status = {idle, ready};

endmodule

// File: rtl/flash_cmd_port_chk.sv
module flash_cmd_port_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       wr_en,
    input logic [7:0] wr_data,
    input logic       rd_en,
    input logic [7:0] rd_data,
    input logic [1:0] status
);

    // R4
    status_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(status[0] && status[1]));

    // R2
    key_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (status[1] && wr_en && wr_data == 8'hB6) |=> !status[1]);

    // R3
    stray_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (status[1] && !(wr_en && wr_data == 8'hB6)) |=> status[1]);

    // R5
    ready_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (status[0] && !rd_en) |=> status[0]);

    // R5
    data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (status[0] && !rd_en) |=> $stable(rd_data));

    // R12
    quiet_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !status[0] |-> rd_data == 8'h00);

    // R13
    ready_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status[0]) |-> $past(status) == 2'b00);

endmodule

bind flash_cmd_port flash_cmd_port_chk i_chk (.*);

// File: tb/test_flash_cmd_port.sv
module test_flash_cmd_port;

    localparam int BUSY = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ecc_bypass = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       rd_en = 1'b0;
    logic [7:0] rd_data;
    logic [1:0] status;

    int tests = 0;
    int fails = 0;

    always #5 clk = ~clk;

    flash_cmd_port i_flash_cmd_port (
        .clk        (clk),
        .rst_n      (rst_n),
        .ecc_bypass (ecc_bypass),
        .wr_en      (wr_en),
        .wr_data    (wr_data),
        .rd_en      (rd_en),
        .rd_data    (rd_data),
        .status     (status)
    );

    // ---------------- behavioural reference model ----------------
    int           mode;          // 0 idle,1 key2,2 opcode,3 params,6 row data,4 busy,5 results
    int           mbusy, mneed, mrow;
    int           mk2, mop;
    int           pq[$];
    int           rq[$];
    int           mmem[256];
    int           mlat[16];
    int           mprot[16];

    function automatic int nparam(input int o);
        case (o)
            0: return 3;   2: return 1;   3: return 2;
            7: return 5;   8: return 2;   9: return 0;
            10: return 2;  11: return 1;  14: return 1;
            default: return -1;
        endcase
    endfunction

    task automatic model_exec();
        int r;
        case (mop)
            0:  mlat[pq[1] % 16] = pq[2];
            3:  rq.push_back(mmem[pq[1]]);
            7:  begin
                    r = ((pq[1] * 256) + pq[2]) % 16;
                    for (int b = 0; b < 16; b++) mmem[r*16 + b] = mlat[b];
                end
            8:  for (int a = (pq[1] % 4) * 64; a < (pq[1] % 4) * 64 + 64; a++) mmem[a] = 0;
            9:  begin
                    for (int a = 0; a < 256; a++) mmem[a] = 0;
                    for (int b = 0; b < 16; b++) begin mlat[b] = 0; mprot[b] = 0; end
                end
            10: for (int b = 0; b < 16; b++) rq.push_back(mprot[b]);
            11: for (int b = 0; b < 16; b++) mprot[b] = mlat[b];
            14: begin rq.push_back(8'h00); rq.push_back(8'h19); end
            default: ;
        endcase
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            mode = 0; mbusy = 0; pq.delete(); rq.delete();
            for (int a = 0; a < 256; a++) mmem[a] = 0;
            for (int b = 0; b < 16; b++) begin mlat[b] = 0; mprot[b] = 0; end
        end else begin
            case (mode)
                0: if (wr_en && wr_data == 8'hB6) mode = 1;
                1: if (wr_en) begin mk2 = int'(wr_data); mode = 2; end
                2: if (wr_en) begin
                       if (nparam(int'(wr_data)) >= 0 && mk2 == (211 + int'(wr_data)) % 256) begin
                           mop = int'(wr_data); mneed = nparam(mop); pq.delete();
                           if (mneed == 0) begin mode = 4; mbusy = BUSY; end
                           else mode = 3;
                       end else mode = 0;
                   end
                3: if (wr_en) begin
                       pq.push_back(int'(wr_data));
                       if (pq.size() == mneed) begin
                           if (mop == 2) begin mrow = 0; mode = 6; end
                           else begin mode = 4; mbusy = BUSY; end
                       end
                   end
                6: if (wr_en) begin
                       if (mrow < 16) mlat[mrow] = int'(wr_data);
                       mrow++;
                       if (mrow == (ecc_bypass ? 18 : 16)) begin mode = 4; mbusy = BUSY; end
                   end
                4: begin
                       mbusy--;
                       if (mbusy == 0) begin
                           model_exec();
                           mode = (rq.size() > 0) ? 5 : 0;
                       end
                   end
                5: if (rd_en) begin
                       void'(rq.pop_front());
                       if (rq.size() == 0) mode = 0;
                   end
                default: mode = 0;
            endcase
        end
    end

    // Per-cycle comparison (R4, R12, R13 across every cycle)
    always @(negedge clk) begin
        if (rst_n) begin
            logic [1:0] est;
            int         erd;
            est = {mode == 0, mode == 5};
            erd = (mode == 5) ? rq[0] : 0;
            tests++;
            if (status !== est || int'(rd_data) != erd) begin
                fails++;
                $display("FAIL R4/R12/R13 cycle model: status=%b rd=%0h expected status=%b rd=%0h",
                         status, rd_data, est, erd);
            end
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic chk(input string tag, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic put(input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic pull(output int v);
        @(negedge clk);
        v = int'(rd_data);
        rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic wait_idle();
        while (status[1] !== 1'b1) @(negedge clk);
    endtask

    task automatic wait_ready();
        while (status[0] !== 1'b1) @(negedge clk);
    endtask

    task automatic cmd(input logic [7:0] o);
        wait_idle();
        put(8'hB6);
        put(8'(8'hD3 + o));
        put(o);
    endtask

    task automatic read_byte(input int off, input int exp, input string tag);
        int v;
        cmd(8'h03); put(8'h00); put(8'(off));
        wait_ready();
        chk({tag, " R5 ready status"}, int'(status), 1);
        pull(v);
        chk(tag, v, exp);
        chk({tag, " R5 idle after read"}, int'(status), 2);
    endtask

    task automatic prog_row(input int hi, input int lo);
        cmd(8'h07); put(8'h00); put(8'(hi)); put(8'(lo)); put(8'h01); put(8'h20);
    endtask

    // ---------------- watchdog ----------------
    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    // ---------------- main sequence ----------------
    initial begin
        int v;
        int n;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 reset status", int'(status), 2);
        chk("R1 reset rd_data", int'(rd_data), 0);
        read_byte(0, 0, "R1 erased array");

        // R2 key start, R7 load row without extra bytes
        wait_idle();
        put(8'hB6);
        chk("R2 idle low after first key", int'(status), 0);
        put(8'hD5); put(8'h02); put(8'h00);
        for (int i = 0; i < 16; i++) put(8'(3*i + 1));
        // R6 program row 5, then read
        prog_row(0, 5);
        read_byte(82, 7, "R6/R7 programmed row 5 byte 2");
        // R6 row number taken modulo row count (0x103 -> row 3)
        prog_row(1, 3);
        read_byte(48, 1, "R6 row modulo");
        // R6 load byte into latch
        cmd(8'h00); put(8'h00); put(8'h02); put(8'hAA);
        prog_row(0, 9);
        read_byte(146, 8'hAA, "R6 load byte");
        read_byte(145, 4, "R6 neighbour byte");

        // R7 extra check bytes consumed when ecc_bypass=1
        wait_idle();
        ecc_bypass = 1'b1;
        cmd(8'h02); put(8'h00);
        for (int i = 0; i < 16; i++) put(8'(8'h50 + i));
        put(8'hB6); put(8'hB6);
        wait_idle();
        ecc_bypass = 1'b0;
        prog_row(0, 12);
        read_byte(207, 8'h5F, "R7 bypass row data");

        // R8 erase sector 1 (rows 4..7)
        cmd(8'h08); put(8'h00); put(8'h01);
        read_byte(82, 0, "R8 erased row");
        read_byte(48, 1, "R8 row 3 kept");
        read_byte(146, 8'hAA, "R8 row 9 kept");

        // R3 bad key and bad opcode
        wait_idle();
        put(8'h12);
        chk("R3 stray byte keeps idle", int'(status), 2);
        put(8'hB6); put(8'hD7); put(8'h03);
        chk("R3 key2 mismatch aborts", int'(status), 2);
        put(8'h00); put(8'h52);
        put(8'hB6); put(8'hD8); put(8'h05);
        chk("R3 unsupported opcode aborts", int'(status), 2);
        read_byte(146, 8'hAA, "R3 no side effect");

        // R10 protect row program and hidden row stream
        cmd(8'h0B); put(8'h00);
        cmd(8'h0A); put(8'h00); put(8'h00);
        wait_ready();
        for (int i = 0; i < 16; i++) begin
            pull(v);
            chk("R10 hidden row byte", v, 8'h50 + i);
        end
        chk("R10 idle after stream", int'(status), 2);

        // R11 temperature
        cmd(8'h0E); put(8'h03);
        wait_ready();
        pull(v); chk("R11 sign byte", v, 8'h00);
        pull(v); chk("R11 magnitude byte", v, 8'h19);

        // R12 writes during busy/result ignored, reads outside result
        pull(v);
        chk("R12 read while idle", v, 0);
        chk("R12 still idle", int'(status), 2);
        cmd(8'h03); put(8'h00); put(8'd207);
        put(8'hB6);
        wait_ready();
        put(8'h55);
        chk("R12 still ready", int'(status), 1);
        pull(v);
        chk("R12 result unchanged", v, 8'h5F);
        chk("R12 idle after result", int'(status), 2);

        // R13 busy window for erase all, R9 effects
        cmd(8'h09);
        n = 0;
        while (status[1] !== 1'b1) begin
            if (status == 2'b00) n++;
            @(negedge clk);
        end
        chk("R13 busy cycles", n, BUSY);
        read_byte(146, 0, "R9 array cleared");
        cmd(8'h0A); put(8'h00); put(8'h00);
        wait_ready();
        for (int i = 0; i < 16; i++) begin
            pull(v);
            chk("R9 protection row cleared", v, 0);
        end
        prog_row(0, 2);
        read_byte(34, 0, "R9 latch cleared");

        repeat (4) @(negedge clk);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule